// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames. A host writes a word into a one-word holding register. When the shift stage is free, the word moves across and is sent: a low start bit, then the data bits least significant first, then an optional parity bit, then one or more high stop bits. The line rests high between frames.

The frame shape is chosen at run time by a set of control inputs:

- a word-length code;
- parity enable, parity sense and a fixed-value parity option;
- a stop-length select;
- a break request that pulls the line low;
- a loopback request that forces the line high.

An external divider supplies a one-cycle `tick` at sixteen times the bit rate. Each bit lasts sixteen ticks. The frame settings are captured when a word enters the shift stage, so later changes to them apply to the next word.

Top module: `uart_tx_frame`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `tx_idle` is 1.
- R2: A frame starts with one 0 bit, followed by the data bits sent least significant bit first. The `wlen` code selects how many data bits are sent: 00 sends 5, 01 sends 6, 10 sends 7 and 11 sends 8. Unused upper bits of `wr_data` are not sent.
- R3: Every start, data and parity bit lasts exactly 16 `tick` pulses. The line changes only on a `tick` or when a new word is loaded.
- R4: With `par_en` = 1 and `par_stick` = 0, one parity bit follows the data bits. With `par_even` = 1 it makes the count of ones in data plus parity even. With `par_even` = 0 it makes that count odd. With `par_en` = 0 no parity bit is sent.
- R5: With `par_en` = 1 and `par_stick` = 1, the parity bit is the constant value of `par_even`.
- R6: With `stop_sel` = 0 the stop period is 16 ticks. With `stop_sel` = 1 it is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words. The line is 1 throughout the stop period.
- R7: `hold_empty` goes to 0 in the cycle after a write. It returns to 1 in the cycle the word moves into the shift stage. `tx_idle` is 1 only when the holding register is empty and no frame is being sent.
- R8: A word written while a frame is in progress waits in the holding register. Its start bit begins on the tick right after the previous stop period ends, with no idle gap.
- R9: While `brk` = 1 and `loop_en` = 0, `txd` is 0, whether or not a frame is in progress.
- R10: While `loop_en` = 1, `txd` is 1, even when `brk` = 1 or a frame is sending a 0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Baud pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Word to transmit |
| wlen | input | 2 | Word-length code (00 = 5 bits … 11 = 8 bits) |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | Even parity sense, or the fixed parity value |
| par_stick | input | 1 | Send fixed-value parity |
| stop_sel | input | 1 | Long stop period |
| brk | input | 1 | Force the line low |
| loop_en | input | 1 | Loopback: force the line high |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register empty |
| tx_idle | output | 1 | Holding register and shift stage both empty |

## Verification
The hardest case to reach is a word waiting in the holding register at the instant the previous stop period ends. The bench reaches it by writing a second word right after the first is loaded. That write keeps `hold_empty` low for a whole frame. The monitor ends a frame when it sees the handover (either `hold_empty` rising or `tx_idle` rising) and checks that the tick count up to that point matches the frame length exactly. Any idle gap or dropped tick between the two frames shows up as a wrong duration. Loopback and break are also applied while a frame is sending, so their override of a live data bit is seen at the pin.

// File: rtl/uart_tx_frame.sv
module uart_tx_frame #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       stop_sel,
  input  logic       brk,
  input  logic       loop_en,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_idle
);
  localparam int CW = $clog2(2 * OS + 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(OS - 1);
  localparam logic [CW-1:0] STOP_1   = CW'(OS);
  localparam logic [CW-1:0] STOP_15  = CW'(OS + OS / 2);
  localparam logic [CW-1:0] STOP_2   = CW'(2 * OS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [7:0]    hold_q, shf_q;
  logic          hold_full, par_q, pen_q, line;
  logic [CW-1:0] tcnt, stop_len;
  logic [2:0]    bidx, blast;

  wire [7:0]    mask      = 8'hFF >> (2'd3 - wlen);
  wire          par_raw   = ^(hold_q & mask);
  wire          par_bit   = par_stick ? par_even : (par_even ? par_raw : ~par_raw);
  wire [CW-1:0] stop_pick = !stop_sel ? STOP_1 : (wlen == 2'd0 ? STOP_15 : STOP_2);
  wire          load      = hold_full && (st == S_IDLE);
  wire          el_done   = tcnt == ((st == S_STOP) ? stop_len - 1'b1 : BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hold_q    <= '0;
      hold_full <= 1'b0;
      shf_q     <= '0;
      tcnt      <= '0;
      bidx      <= '0;
      blast     <= '0;
      par_q     <= 1'b0;
      pen_q     <= 1'b0;
      stop_len  <= STOP_1;
    end else begin
      if (wr_en) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end

      if (load) begin
        shf_q    <= hold_q;
        blast    <= 3'd4 + {1'b0, wlen};
        par_q    <= par_bit;
        pen_q    <= par_en;
        stop_len <= stop_pick;
        st       <= S_START;
        tcnt     <= '0;
        bidx     <= '0;
      end else if (tick && st != S_IDLE) begin
        if (!el_done) begin
          tcnt <= tcnt + 1'b1;
        end else begin
          tcnt <= '0;
          case (st)
            S_START: st <= S_DATA;
            S_DATA: begin
              shf_q <= {1'b0, shf_q[7:1]};
              bidx  <= bidx + 1'b1;
              if (bidx == blast) st <= pen_q ? S_PAR : S_STOP;
            end
            S_PAR:   st <= S_STOP;
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = shf_q[0];
      S_PAR:   line = par_q;
      default: line = 1'b1;
    endcase
  end

  assign txd        = loop_en | (~brk & line);
  assign hold_empty = ~hold_full;
  assign tx_idle    = ~hold_full & (st == S_IDLE);
endmodule

module uart_tx_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic wr_en,
  input logic brk,
  input logic loop_en,
  input logic txd,
  input logic hold_empty,
  input logic tx_idle
);
  // R1
  idle_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> hold_empty);

  // R7
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hold_empty) && !brk && !loop_en) |-> !txd);

  // R3
  tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && hold_empty) |=> ($stable(txd) || !$stable(brk) || !$stable(loop_en)));
endmodule

bind uart_tx_frame uart_tx_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .brk(brk),
  .loop_en(loop_en), .txd(txd), .hold_empty(hold_empty), .tx_idle(tx_idle)
);

// File: tb/sim_uart_tx_frame.sv
module sim_uart_tx_frame;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] wlen = 0;
  logic par_en = 0, par_even = 0, par_stick = 0, stop_sel = 0, brk = 0, loop_en = 0;
  logic txd, hold_empty, tx_idle;

  uart_tx_frame u0 (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [7:0] d;
    logic [1:0] wl;
    logic pe, ev, sk, sp;
    string tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int n_chk = 0, n_bad = 0;
  bit in_frame = 0;
  int cnt, idx, nb, tot;
  logic [11:0] expv, obsv;
  logic prev_txd, prev_he;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic pe, input logic ev,
                      input logic sk, input logic sp, input bit push, input string tag);
    item_t it;
    @(negedge clk);
    wlen = wl; par_en = pe; par_even = ev; par_stick = sk; stop_sel = sp;
    wr_data = d; wr_en = 1;
    if (push) begin
      it.d = d; it.wl = wl; it.pe = pe; it.ev = ev; it.sk = sk; it.sp = sp; it.tag = tag;
      q.push_back(it);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_idle && !in_frame && q.size() == 0));
    repeat (3) @(negedge clk);
  endtask

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  initial begin
    prev_txd = 1; prev_he = 1;
    forever begin
      @(negedge clk);
      #1;
      if (in_frame && (tx_idle || (!prev_he && hold_empty))) begin
        chk(obsv == expv, cur.tag, 32'(obsv), 32'(expv));
        chk(cnt == tot, cur.sp ? "R6" : "R3", cnt, tot);
        in_frame = 0;
      end
      if (!in_frame && rst_n && prev_txd && !txd && q.size() > 0) begin
        logic ones;
        cur = q.pop_front();
        in_frame = 1; cnt = tick; idx = 0; obsv = '0; expv = '0;
        nb = 6 + int'(cur.wl) + int'(cur.pe);
        for (int k = 0; k < 5 + int'(cur.wl); k++) expv[1 + k] = cur.d[k];
        ones = ^(cur.d & (8'hFF >> (2'd3 - cur.wl)));
        if (cur.pe) expv[6 + cur.wl] = cur.sk ? cur.ev : (cur.ev ? ones : ~ones);
        expv[nb] = 1'b1;
        tot = 16 * nb + (cur.sp ? (cur.wl == 2'd0 ? 24 : 32) : 16);
      end else if (in_frame) begin
        cnt += int'(tick);
      end
      if (in_frame && idx <= nb && cnt == ((idx < nb) ? 16 * idx + 8 : 16 * nb + 4)) begin
        obsv[idx] = txd;
        idx++;
      end
      prev_txd = txd; prev_he = hold_empty;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1, "R1", txd, 1);
    chk(hold_empty == 1, "R1", hold_empty, 1);
    chk(tx_idle == 1, "R1", tx_idle, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    send(8'hA5, 2'd3, 0, 0, 0, 0, 1, "R2");
    chk(hold_empty == 0, "R7", hold_empty, 0);
    @(negedge clk);
    chk(hold_empty == 1, "R7", hold_empty, 1);
    chk(tx_idle == 0, "R7", tx_idle, 0);
    wait_idle();

    send(8'hF3, 2'd0, 1, 1, 0, 1, 1, "R4");
    wait_idle();
    send(8'h2D, 2'd1, 1, 0, 0, 1, 1, "R4");
    wait_idle();
    send(8'h55, 2'd2, 1, 1, 1, 0, 1, "R5");
    wait_idle();
    send(8'hFF, 2'd3, 1, 0, 1, 1, 1, "R5");
    wait_idle();

    send(8'h3C, 2'd3, 1, 1, 0, 0, 1, "R8");
    send(8'hC3, 2'd3, 1, 1, 0, 0, 1, "R8");
    @(negedge clk);
    chk(hold_empty == 0, "R8", hold_empty, 0);
    wait_idle();

    @(negedge clk) brk = 1;
    @(negedge clk);
    chk(txd == 0, "R9", txd, 0);
    loop_en = 1;
    @(negedge clk);
    chk(txd == 1, "R10", txd, 1);
    brk = 0; loop_en = 0;

    send(8'h00, 2'd3, 0, 0, 0, 0, 0, "");
    repeat (40) @(negedge clk);
    chk(txd == 0, "R2", txd, 0);
    loop_en = 1;
    @(negedge clk);
    chk(txd == 1, "R10", txd, 1);
    loop_en = 0;
    @(negedge clk);
    chk(txd == 0, "R10", txd, 0);
    wait_idle();
    send(8'hFF, 2'd3, 0, 0, 0, 0, 0, "");
    repeat (60) @(negedge clk);
    chk(txd == 1, "R9", txd, 1);
    brk = 1;
    @(negedge clk);
    chk(txd == 0, "R9", txd, 0);
    brk = 0;
    wait_idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule